// File: doc/BRIEF.md
# General-Purpose Pin Controller with Edge and Level Interrupts

This block is a memory-mapped controller for a bank of general-purpose pins, 32 by default. Software uses a plain single-word request bus to read and write thirteen word-wide registers. Each register holds one bit per pin. Per pin, software chooses whether the incoming level is sampled, whether the pad is driven, the value driven, and an inversion mask that is XORed onto that value.

Each pin's sampled input feeds four pending flags: rising edge, falling edge, high level and low level. Every flag is recorded at all times, and each flag stays set until software clears it by writing a 1 to it. Each kind of flag has its own enable mask. A single interrupt request goes high whenever any enabled flag is set. That line is meant to feed a platform interrupt controller.

Pins are sampled through a two-stage synchronizer. An edge is detected by comparing the current synchronized, input-enable-gated sample with the sample from the cycle before.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is low and right after it, every register reads zero except the low-level pending register, which reads all ones. The pad outputs, pad output enables and the interrupt are zero.
- R2: A read returns the selected register zero-extended in the same cycle. The read data is zero when no read is requested and when the word offset is 13 or above. Writes to those offsets and to the input-value offset change nothing.
- R3: The pad outputs equal the output value XOR the inversion mask, and the pad output enables equal the output-enable register. Both take new values in the cycle after the write.
- R4: The input-value register equals the pad input delayed by two clock edges, ANDed with the current input-enable mask. A pin whose input enable is clear therefore reads 0.
- R5: A rising pending bit sets at the edge after the sampled input of its pin changes from 0 to 1. A falling pending bit sets in the same way when the sampled input changes from 1 to 0.
- R6: A high pending bit sets at every edge where the sampled input is 1, and a low pending bit sets at every edge where the sampled input is 0.
- R7: Pending bits are sticky. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If the set condition is true in the same cycle, the set wins over the clear.
- R8: Pending bits are recorded whatever the enable masks hold. With every enable mask at zero, the interrupt stays low.
- R9: The interrupt is high exactly when some pin has a pending bit set together with the matching enable bit. It changes in the cycle after the write to an enable or pending register.
- R10: The word offsets, with byte address = 4 × offset, are: 0 input value, 1 input enable, 2 output enable, 3 output value, 4 to 7 rise/fall/high/low enable, 8 to 11 rise/fall/high/low pending, 12 output inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReq | input | 1 | Bus request for this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the cycle of the read request |
| padIn | input | NUM_PINS | Asynchronous pin levels |
| padOut | output | NUM_PINS | Driven pin values |
| padOe | output | NUM_PINS | Pin drive enables |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the bus fields are stable and defined for the whole cycle of each request, and that requests are single cycles with no overlap. They also assume that pad inputs may change at any time, since only the synchronized copy is checked. The stimulus drives every bus field and pad level on the falling clock edge. It issues each request for exactly one cycle followed by an idle cycle. Some pad inputs come back from the block's own driven outputs, so the level seen at a pin always reflects the configured drive.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int REG_COUNT  = 13;
  localparam int KIND_COUNT = 4;
  localparam int KIND_RISE  = 0;
  localparam int KIND_FALL  = 1;
  localparam int KIND_HIGH  = 2;
  localparam int KIND_LOW   = 3;

  typedef enum logic [3:0] {
    SEL_IN_VAL    = 4'd0,
    SEL_IN_EN     = 4'd1,
    SEL_OUT_EN    = 4'd2,
    SEL_OUT_VAL   = 4'd3,
    SEL_RISE_EN   = 4'd4,
    SEL_FALL_EN   = 4'd5,
    SEL_HIGH_EN   = 4'd6,
    SEL_LOW_EN    = 4'd7,
    SEL_RISE_PEND = 4'd8,
    SEL_FALL_PEND = 4'd9,
    SEL_HIGH_PEND = 4'd10,
    SEL_LOW_PEND  = 4'd11,
    SEL_OUT_INV   = 4'd12,
    SEL_NONE      = 4'd15
  } regSel_e;

  typedef struct packed {
    logic                  wrInEn;
    logic                  wrOutEn;
    logic                  wrOutVal;
    logic                  wrOutInv;
    logic [KIND_COUNT-1:0] wrIrqEn;
    logic [KIND_COUNT-1:0] clrPend;
    logic                  rdEn;
    regSel_e               rdSel;
  } gpioStrobe_t;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output gpioStrobe_t       strobe
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             hit;
  logic             wrHit;
  regSel_e          sel;
  logic             unusedAddrBits;

  assign unusedAddrBits = ^busAddr[1:0];
  assign wordIdx        = busAddr[ADDR_W-1:2];
  assign hit            = wordIdx < IDX_W'(REG_COUNT);
  assign sel            = hit ? regSel_e'(wordIdx[3:0]) : SEL_NONE;
  assign wrHit          = busReq & busWe & hit;

  always_comb begin
    strobe          = '0;
    strobe.rdEn     = busReq & ~busWe & hit;
    strobe.rdSel    = sel;
    strobe.wrInEn   = wrHit && (sel == SEL_IN_EN);
    strobe.wrOutEn  = wrHit && (sel == SEL_OUT_EN);
    strobe.wrOutVal = wrHit && (sel == SEL_OUT_VAL);
    strobe.wrOutInv = wrHit && (sel == SEL_OUT_INV);
    for (int k = 0; k < KIND_COUNT; k++) begin
      strobe.wrIrqEn[k] = wrHit && (sel == regSel_e'(4'(int'(SEL_RISE_EN) + k)));
      strobe.clrPend[k] = wrHit && (sel == regSel_e'(4'(int'(SEL_RISE_PEND) + k)));
    end
  end

endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank #(
  parameter int WIDTH      = 32,
  parameter bit RESET_ONES = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] setVec,
  input  logic [WIDTH-1:0] clrVec,
  output logic [WIDTH-1:0] pend
);

  // Set has priority over a write-one clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pend <= RESET_ONES ? '1 : '0;
    else       pend <= (pend & ~clrVec) | setVec;
  end

endmodule

// File: rtl/gpio_dp.sv
module gpio_dp
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  gpioStrobe_t         strobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqReq
);

  logic [NUM_PINS-1:0] wrPins;
  logic [NUM_PINS-1:0] inEn, outEn, outVal, outInv;
  logic [NUM_PINS-1:0] syncA, syncB, curIn, prevIn;
  logic [NUM_PINS-1:0] irqEn   [KIND_COUNT];
  logic [NUM_PINS-1:0] pendVec [KIND_COUNT];
  logic [NUM_PINS-1:0] setVec  [KIND_COUNT];
  logic [NUM_PINS-1:0] clrVec  [KIND_COUNT];
  logic [NUM_PINS-1:0] anyHit;
  logic [NUM_PINS-1:0] rdVal;

  assign wrPins = wrData[NUM_PINS-1:0];

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inEn   <= '0;
      outEn  <= '0;
      outVal <= '0;
      outInv <= '0;
    end else begin
      if (strobe.wrInEn)   inEn   <= wrPins;
      if (strobe.wrOutEn)  outEn  <= wrPins;
      if (strobe.wrOutVal) outVal <= wrPins;
      if (strobe.wrOutInv) outInv <= wrPins;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < KIND_COUNT; k++) irqEn[k] <= '0;
    end else begin
      for (int k = 0; k < KIND_COUNT; k++)
        if (strobe.wrIrqEn[k]) irqEn[k] <= wrPins;
    end
  end

  // two-stage input synchronizer and previous-sample register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      prevIn <= '0;
    end else begin
      syncA  <= padIn;
      syncB  <= syncA;
      prevIn <= curIn;
    end
  end

  assign curIn = syncB & inEn;

  always_comb begin
    setVec[KIND_RISE] = curIn & ~prevIn;
    setVec[KIND_FALL] = ~curIn & prevIn;
    setVec[KIND_HIGH] = curIn;
    setVec[KIND_LOW]  = ~curIn;
    for (int k = 0; k < KIND_COUNT; k++)
      clrVec[k] = strobe.clrPend[k] ? wrPins : '0;
  end

  for (genvar k = 0; k < KIND_COUNT; k++) begin : g_bank
    gpio_pend_bank #(
      .WIDTH     (NUM_PINS),
      .RESET_ONES(k == KIND_LOW)
    ) u_bank (
      .clk   (clk),
      .rstN  (rstN),
      .setVec(setVec[k]),
      .clrVec(clrVec[k]),
      .pend  (pendVec[k])
    );
  end

  always_comb begin
    anyHit = '0;
    for (int k = 0; k < KIND_COUNT; k++) anyHit |= irqEn[k] & pendVec[k];
  end
  assign irqReq = |anyHit;

  assign padOut = outVal ^ outInv;
  assign padOe  = outEn;

  always_comb begin
    case (strobe.rdSel)
      SEL_IN_VAL:    rdVal = curIn;
      SEL_IN_EN:     rdVal = inEn;
      SEL_OUT_EN:    rdVal = outEn;
      SEL_OUT_VAL:   rdVal = outVal;
      SEL_RISE_EN:   rdVal = irqEn[KIND_RISE];
      SEL_FALL_EN:   rdVal = irqEn[KIND_FALL];
      SEL_HIGH_EN:   rdVal = irqEn[KIND_HIGH];
      SEL_LOW_EN:    rdVal = irqEn[KIND_LOW];
      SEL_RISE_PEND: rdVal = pendVec[KIND_RISE];
      SEL_FALL_PEND: rdVal = pendVec[KIND_FALL];
      SEL_HIGH_PEND: rdVal = pendVec[KIND_HIGH];
      SEL_LOW_PEND:  rdVal = pendVec[KIND_LOW];
      SEL_OUT_INV:   rdVal = outInv;
      default:       rdVal = '0;
    endcase
    rdData = strobe.rdEn ? DATA_W'(rdVal) : '0;
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busReq,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqOut
);

  gpioStrobe_t strobe;

  gpio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busReq (busReq),
    .busWe  (busWe),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  gpio_dp #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(busWdata),
    .padIn (padIn),
    .rdData(busRdata),
    .padOut(padOut),
    .padOe (padOe),
    .irqReq(irqOut)
  );

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic                busReq,
  input logic                busWe,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busWdata,
  input logic [DATA_W-1:0]   busRdata,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic                irqOut
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]    wordIdx;
  logic [NUM_PINS-1:0] enShadow [4];
  logic                enAny;

  assign wordIdx = busAddr[ADDR_W-1:2];

  // independent record of the four interrupt-enable masks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < 4; k++) enShadow[k] <= '0;
    end else if (busReq && busWe) begin
      for (int k = 0; k < 4; k++)
        if (wordIdx == IDX_W'(4 + k)) enShadow[k] <= busWdata[NUM_PINS-1:0];
    end
  end

  always_comb begin
    enAny = 1'b0;
    for (int k = 0; k < 4; k++) enAny |= |enShadow[k];
  end

  a_r2_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |-> busRdata == '0);

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWe && wordIdx >= IDX_W'(13)) |-> busRdata == '0);

  a_r3_oe_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWe && wordIdx == IDX_W'(2)) |=> padOe == $past(busWdata[NUM_PINS-1:0]));

  a_r3_pads_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !(busReq && busWe) |=> ($stable(padOut) && $stable(padOe)));

  a_r8_no_irq_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enAny |-> !irqOut);

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NUM_PINS(NUM_PINS),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (.*);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0;
  logic        busWe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] padIn, padOut, padOe, tbDrive = '0;
  logic        irqOut;
  logic        started = 1'b0;
  int          total = 0;
  int          bad = 0;

  always #4 clk = ~clk;

  // driven pins loop back, undriven pins take the bench level
  assign padIn = (padOe & padOut) | (~padOe & tbDrive);

  gpio_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .irqOut(irqOut)
  );

  // behavioural reference
  logic [31:0] mReg [13];
  logic [31:0] syncQ [$];
  logic [31:0] mPrev, mCur, mPad, mSet, mClr;
  int          mWord;

  function automatic logic [31:0] mRead(int w);
    if (w == 0) return syncQ[0] & mReg[1];
    if (w < 13) return mReg[w];
    return 32'h0;
  endfunction

  function automatic logic mIrq();
    return |((mReg[4] & mReg[8]) | (mReg[5] & mReg[9]) |
             (mReg[6] & mReg[10]) | (mReg[7] & mReg[11]));
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 13; i++) mReg[i] = 32'h0;
      mReg[11] = 32'hFFFF_FFFF;
      mPrev = 32'h0;
      syncQ = {};
      syncQ.push_back(32'h0);
      syncQ.push_back(32'h0);
    end else begin
      mPad  = (mReg[2] & (mReg[3] ^ mReg[12])) | (~mReg[2] & tbDrive);
      mCur  = syncQ[0] & mReg[1];
      mWord = int'(busAddr[5:2]);
      for (int k = 0; k < 4; k++) begin
        case (k)
          0:       mSet = mCur & ~mPrev;
          1:       mSet = ~mCur & mPrev;
          2:       mSet = mCur;
          default: mSet = ~mCur;
        endcase
        mClr = (busReq && busWe && mWord == 8 + k) ? busWdata : 32'h0;
        mReg[8+k] = (mReg[8+k] & ~mClr) | mSet;
      end
      if (busReq && busWe && ((mWord >= 1 && mWord <= 7) || mWord == 12))
        mReg[mWord] = busWdata;
      mPrev = mCur;
      syncQ.push_back(mPad);
      void'(syncQ.pop_front());
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (rstN && started) begin
      chk("R3 padOut", padOut, mReg[3] ^ mReg[12]);
      chk("R3 padOe", padOe, mReg[2]);
      chk("R9 irqOut", {31'b0, irqOut}, {31'b0, mIrq()});
      chk("R2 busRdata", busRdata,
          (busReq && !busWe) ? mRead(int'(busAddr[5:2])) : 32'h0);
    end
  end

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    busReq = 1'b1; busWe = 1'b1; busAddr = 6'(w * 4); busWdata = d;
    @(negedge clk);
    busReq = 1'b0; busWe = 1'b0;
  endtask

  task automatic rd(input int w, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busReq = 1'b1; busWe = 1'b0; busAddr = 6'(w * 4);
    #2;
    chk(tag, busRdata, exp);
    @(negedge clk);
    busReq = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'b0, irqOut}, 32'h0);
    chk("R1 padOe in reset", padOe, 32'h0);
    rstN = 1'b1;
    started = 1'b1;

    // R1 reset values, R2 unmapped offsets
    for (int w = 0; w < 13; w++)
      rd(w, (w == 11) ? 32'hFFFF_FFFF : 32'h0, "R1 reset value");
    for (int w = 13; w < 16; w++) rd(w, 32'h0, "R2 unmapped read");
    wr(14, 32'hDEAD_BEEF);
    rd(14, 32'h0, "R2 unmapped write ignored");

    // R10 register placement, R3 pad outputs
    wr(2, 32'hFFFF_0000);
    wr(3, 32'hA5A5_C3C3);
    wr(12, 32'h0F0F_0000);
    rd(2, 32'hFFFF_0000, "R10 output enable offset");
    rd(3, 32'hA5A5_C3C3, "R10 output value offset");
    rd(12, 32'h0F0F_0000, "R10 inversion offset");
    chk("R3 pad value", padOut, 32'hAAAA_C3C3);
    chk("R3 pad enable", padOe, 32'hFFFF_0000);

    // R2 write to input value ignored; R4 gating with inputs disabled
    wr(0, 32'h1234_5678);
    rd(0, 32'h0, "R2 R4 input value read-only and gated");

    // R4 synchronized input
    tbDrive = 32'h0000_5A5A;
    wr(1, 32'hFFFF_FFFF);
    idle(3);
    rd(0, 32'hAAAA_5A5A, "R4 input value");
    wr(1, 32'h0000_FF00);
    rd(0, 32'h0000_5A00, "R4 partial input enable");
    wr(1, 32'hFFFF_FFFF);
    idle(4);

    // R6 levels after clearing everything
    for (int w = 8; w < 12; w++) wr(w, 32'hFFFF_FFFF);
    rd(8, 32'h0, "R5 rise clear");
    rd(9, 32'h0, "R5 fall clear");
    rd(10, 32'hAAAA_5A5A, "R6 high level");
    rd(11, 32'h5555_A5A5, "R6 low level");

    // R5 edges, R8 with all enables off
    tbDrive = 32'h0000_A55A;
    idle(4);
    rd(8, 32'h0000_A500, "R5 rising edges");
    rd(9, 32'h0000_5A00, "R5 falling edges");
    chk("R8 pending with enables off", {31'b0, irqOut}, 32'h0);

    // R7 sticky and write-one-to-clear
    wr(8, 32'h0);
    rd(8, 32'h0000_A500, "R7 write zero keeps");
    wr(8, 32'h0000_A000);
    rd(8, 32'h0000_0500, "R7 write one clears");
    wr(10, 32'hFFFF_FFFF);
    rd(10, 32'hAAAA_A55A, "R7 level sets again");

    // R9 interrupt per kind
    wr(4, 32'h0000_0100);
    chk("R9 rise irq", {31'b0, irqOut}, 32'h1);
    wr(4, 32'h0);
    chk("R9 rise irq off", {31'b0, irqOut}, 32'h0);
    wr(7, 32'h0000_0001);
    chk("R9 low irq", {31'b0, irqOut}, 32'h1);
    wr(7, 32'h0);
    chk("R9 low irq off", {31'b0, irqOut}, 32'h0);
    wr(5, 32'h0000_0200);
    chk("R9 fall irq", {31'b0, irqOut}, 32'h1);
    wr(9, 32'h0000_0200);
    chk("R9 irq drops on pending clear", {31'b0, irqOut}, 32'h0);
    wr(5, 32'h0);
    wr(6, 32'h0000_0002);
    chk("R9 high irq", {31'b0, irqOut}, 32'h1);
    wr(6, 32'h0);
    chk("R9 high irq off", {31'b0, irqOut}, 32'h0);

    // R3 inversion on driven pins, loopback changes seen on input
    wr(12, 32'hFFFF_FFFF);
    chk("R3 inverted pads", padOut, 32'h5A5A_3C3C);
    idle(3);
    rd(0, 32'h5A5A_A55A, "R4 loopback input");

    idle(2);
    finishRun();
  end

endmodule